// File: doc/BRIEF.md
# Serial Flash Transfer Engine

This block is a register-programmed SPI master that moves a burst of up to 64 bytes to and from one serial flash device. Software fills a 64-byte data window with the bytes to send, writes the length of the transfer as a bit count, and writes a start bit. The engine drives SCK in SPI mode 0 and sends the window byte by byte, most significant bit first. If capture is enabled, it writes each byte received on MISO back into the same window position that the byte was sent from.

When the last bit completes, the engine sets a sticky completion flag, which stays set until software clears it. A per-transfer hold bit decides whether chip select stays asserted after the burst, so that a command and the data phase after it can be split across several bursts. A soft-reset bit stops a burst at once and releases the pins. The SCK half period is a fixed number of system clocks, chosen by a parameter.

The register interface is a simple 32-bit write strobe with a combinational read. Offsets 0x40 to 0x7C map the window as 16 little-endian words. Offsets that are not listed below read as zero.

Top module: `sfc_xfer_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck and spi_mosi are 0, the buffer reads as zero, and every status bit reads 0. Any offset below 0x40 that is not one of 0x00, 0x08, 0x1C, 0x20, 0x2C or 0x30 reads as zero.
- R2: Writing 1 to bit 18 of offset 0x00 while idle starts a burst. spi_cs_n goes low in the next cycle, and bit 18 of offset 0x00 reads 1 until the burst ends.
- R3: Bits [8:0] of offset 0x20 hold the bit count. The burst length is (count[8:3]+1)×8 bits, so the low three bits are ignored. Each bit is one SCK period of HALF_DIV clocks low followed by HALF_DIV clocks high, with SCK idling low.
- R4: Byte k of the burst is bits [8(k%4)+7 : 8(k%4)] of the word at offset 0x40+4⌊k/4⌋. Bytes go out in increasing k, MSB first. MOSI changes only on falling SCK and is 0 when idle.
- R5: When bit 0 of offset 0x1C is 1 at start, MISO is sampled on each rising SCK edge, and each full received byte replaces the buffer byte it was sent from. When the bit is 0, the buffer is left unchanged.
- R6: Bit 4 of offset 0x30 becomes 1 on the cycle the last falling SCK edge occurs. It stays 1 until software writes 0 to it.
- R7: If bit 30 of offset 0x2C was 1 at start, spi_cs_n stays low after the burst. Otherwise spi_cs_n returns high on the last falling SCK edge.
- R8: A start request made while a burst is running has no effect on the pins or on the burst length.
- R9: Writing 1 to bit 31 of offset 0x30 stops any burst. It sets SCK low, releases chip select, clears the busy and done bits, and keeps the buffer contents.
- R10: Bit 17 of offset 0x08 is a read/write bit that resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (7) | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions check the following on every cycle: SCK stays low and chip select stays asserted whenever the sequencer is idle or running respectively, MOSI holds steady through each high SCK phase, the bit index never moves backwards within a burst, the completion flag is set and kept, and soft reset returns the sequencer to idle. Some behaviours can only be shown by the bench scenarios, because they depend on data and length: the byte and bit order on MOSI, the overwrite of captured bytes, the burst length that follows from the count field, chip-select hold across bursts, and an ignored second start. A behavioural pin model checks these by comparing SCK, chip select and MOSI on every clock and by reading back the buffer after each burst.

// File: rtl/sfc_pkg.sv
// sfc_pkg: register offsets and field positions shared by the transfer engine.
// Assumes byte offsets on a 4-byte stride, with the data window directly above the registers.
package sfc_pkg;
    localparam int unsigned OFS_CMD   = 32'h00;
    localparam int unsigned OFS_CTRL  = 32'h08;
    localparam int unsigned OFS_USER  = 32'h1C;
    localparam int unsigned OFS_LEN   = 32'h20;
    localparam int unsigned OFS_CSCTL = 32'h2C;
    localparam int unsigned OFS_SLV   = 32'h30;

    localparam int unsigned START_BIT = 18;
    localparam int unsigned BUSY_BIT  = 18;
    localparam int unsigned BUSEN_BIT = 17;
    localparam int unsigned CAPEN_BIT = 0;
    localparam int unsigned HOLD_BIT  = 30;
    localparam int unsigned DONE_BIT  = 4;
    localparam int unsigned SRST_BIT  = 31;

    typedef enum logic [0:0] {
        SQ_IDLE  = 1'b0,
        SQ_SHIFT = 1'b1
    } sq_state_t;
endpackage

// File: rtl/sfc_buffer.sv
// sfc_buffer: byte-organised data window.
// The bus side writes and reads whole little-endian words. The engine side reads any byte
// and writes back one received byte. An engine write takes priority over a bus write to the same byte.
// Assumes BUF_BYTES is a power of two of at least 4.
module sfc_buffer #(
    parameter int unsigned BUF_BYTES  = 64,
    parameter int unsigned BYTE_IDX_W = $clog2(BUF_BYTES),
    parameter int unsigned WORD_W     = BYTE_IDX_W - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [WORD_W-1:0]     bus_word,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [BYTE_IDX_W-1:0] eng_ridx,
    output logic [7:0]            eng_rbyte,
    input  logic                  eng_we,
    input  logic [BYTE_IDX_W-1:0] eng_widx,
    input  logic [7:0]            eng_wbyte
);
    logic [7:0] mem [BUF_BYTES];

    // Byte storage: clear on reset, then engine write-back or bus word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BUF_BYTES; b++) mem[b] <= '0;
        end else begin
            for (int b = 0; b < BUF_BYTES; b++) begin
                if (eng_we && eng_widx == BYTE_IDX_W'(b))
                    mem[b] <= eng_wbyte;
                else if (bus_we && bus_word == WORD_W'(b / 4))
                    mem[b] <= bus_wdata[8*(b%4) +: 8];
            end
        end
    end

    // Bus read: assemble the addressed word, lowest byte first.
    always_comb begin
        for (int k = 0; k < 4; k++) bus_rdata[8*k +: 8] = mem[{bus_word, 2'(k)}];
    end

    // Engine read: the byte the sequencer loads next.
    always_comb eng_rbyte = mem[eng_ridx];
endmodule

// File: rtl/sfc_shifter.sv
// sfc_shifter: SPI mode-0 sequencer.
// On a start request it latches the length, capture and hold settings. It then runs one SCK
// period of 2*HALF_DIV clocks per bit, MSB first, and loads a new byte from the buffer at each
// byte boundary. If capture is on, it writes each received byte back in place.
// Assumes HALF_DIV >= 2. Soft reset acts like reset but leaves the buffer alone.
module sfc_shifter
    import sfc_pkg::*;
#(
    parameter int unsigned BUF_BYTES  = 64,
    parameter int unsigned HALF_DIV   = 2,
    parameter int unsigned BYTE_IDX_W = $clog2(BUF_BYTES),
    parameter int unsigned CNT_W      = BYTE_IDX_W + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_req,
    input  logic                  soft_rst,
    input  logic                  capture_en,
    input  logic                  cs_hold,
    input  logic [BYTE_IDX_W-1:0] last_byte,
    input  logic                  miso,
    input  logic [7:0]            buf_rbyte,
    output logic [BYTE_IDX_W-1:0] buf_ridx,
    output logic                  buf_we,
    output logic [BYTE_IDX_W-1:0] buf_widx,
    output logic [7:0]            buf_wbyte,
    output logic                  sck,
    output logic                  cs_act,
    output logic                  mosi,
    output logic                  busy,
    output logic                  fin
);
    localparam int unsigned     DIV_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    sq_state_t        state_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] bit_q, last_q;
    logic [7:0]       tx_q, rx_q;
    logic             sck_q, cs_q, cap_q, hold_q;
    logic             tick, fall, end_bit, byte_end;

    // Edge timing and boundary decode for the current bit.
    always_comb begin
        busy     = (state_q == SQ_SHIFT);
        tick     = busy && (div_q == DIV_LAST);
        fall     = tick && sck_q;
        end_bit  = (bit_q == last_q);
        byte_end = (bit_q[2:0] == 3'b111);
    end

    // Buffer access: next byte to load, and received-byte write-back at byte end.
    always_comb begin
        buf_ridx  = busy ? (bit_q[CNT_W-1:3] + BYTE_IDX_W'(1)) : '0;
        buf_we    = fall && cap_q && byte_end;
        buf_widx  = bit_q[CNT_W-1:3];
        buf_wbyte = rx_q;
        fin       = fall && end_bit;
    end

    // Sequencer: start latch, divider, SCK toggling, shift and capture.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state_q <= SQ_IDLE;
            div_q   <= '0;
            bit_q   <= '0;
            last_q  <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            sck_q   <= 1'b0;
            cs_q    <= 1'b0;
            cap_q   <= 1'b0;
            hold_q  <= 1'b0;
        end else if (state_q == SQ_IDLE) begin
            if (start_req) begin
                state_q <= SQ_SHIFT;
                div_q   <= '0;
                bit_q   <= '0;
                last_q  <= {last_byte, 3'b111};
                tx_q    <= buf_rbyte;
                rx_q    <= '0;
                sck_q   <= 1'b0;
                cs_q    <= 1'b1;
                cap_q   <= capture_en;
                hold_q  <= cs_hold;
            end
        end else if (tick) begin
            div_q <= '0;
            if (!sck_q) begin
                sck_q <= 1'b1;
                rx_q  <= {rx_q[6:0], miso};
            end else begin
                sck_q <= 1'b0;
                if (end_bit) begin
                    state_q <= SQ_IDLE;
                    cs_q    <= hold_q;
                end else begin
                    bit_q <= bit_q + CNT_W'(1);
                    tx_q  <= byte_end ? buf_rbyte : {tx_q[6:0], 1'b0};
                end
            end
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // Pin drive from the sequencer state.
    always_comb begin
        sck    = sck_q;
        cs_act = cs_q;
        mosi   = busy & tx_q[7];
    end

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_q); // R3
    AST_CS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cs_q); // R2
    AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        busy && sck_q && $past(sck_q) |-> $stable(mosi)); // R4
    AST_BIT_NO_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> bit_q >= $past(bit_q)); // R8
    AST_SRST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !busy && !cs_q && !sck_q); // R9
endmodule

// File: rtl/sfc_regs.sv
// sfc_regs: register decode, configuration storage, done flag and read multiplexer.
// Assumes the data window starts at offset BUF_BYTES (top address bit set) and the registers
// sit below it. Start and soft reset are single-cycle pulses taken straight from the write strobe.
module sfc_regs
    import sfc_pkg::*;
#(
    parameter int unsigned BUF_BYTES  = 64,
    parameter int unsigned BYTE_IDX_W = $clog2(BUF_BYTES),
    parameter int unsigned CNT_W      = BYTE_IDX_W + 3,
    parameter int unsigned ADDR_W     = BYTE_IDX_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [31:0]           buf_rdata,
    output logic                  buf_we,
    output logic [ADDR_W-4:0]     buf_word,
    input  logic                  busy,
    input  logic                  fin,
    output logic                  start_req,
    output logic                  soft_rst,
    output logic                  capture_en,
    output logic                  cs_hold,
    output logic [BYTE_IDX_W-1:0] last_byte,
    output logic                  done
);
    localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_USER  = ADDR_W'(OFS_USER);
    localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(OFS_LEN);
    localparam logic [ADDR_W-1:0] A_CSCTL = ADDR_W'(OFS_CSCTL);
    localparam logic [ADDR_W-1:0] A_SLV   = ADDR_W'(OFS_SLV);

    logic             is_buf, wr_slv;
    logic             busen_q, cap_q, hold_q, done_q;
    logic [CNT_W-1:0] cnt_q;

    // Address decode and command pulses.
    always_comb begin
        is_buf    = reg_addr[ADDR_W-1];
        buf_we    = reg_wr && is_buf;
        buf_word  = reg_addr[ADDR_W-2:2];
        wr_slv    = reg_wr && (reg_addr == A_SLV);
        start_req = reg_wr && (reg_addr == A_CMD) && reg_wdata[START_BIT];
        soft_rst  = wr_slv && reg_wdata[SRST_BIT];
    end

    // Configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busen_q <= 1'b1;
            cap_q   <= 1'b0;
            hold_q  <= 1'b0;
            cnt_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL)  busen_q <= reg_wdata[BUSEN_BIT];
            if (reg_addr == A_USER)  cap_q   <= reg_wdata[CAPEN_BIT];
            if (reg_addr == A_CSCTL) hold_q  <= reg_wdata[HOLD_BIT];
            if (reg_addr == A_LEN)   cnt_q   <= reg_wdata[CNT_W-1:0];
        end
    end

    // Sticky done flag: soft reset clears, completion sets, software write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) done_q <= 1'b0;
        else if (fin)           done_q <= 1'b1;
        else if (wr_slv)        done_q <= reg_wdata[DONE_BIT];
    end

    // Settings handed to the sequencer.
    always_comb begin
        capture_en = cap_q;
        cs_hold    = hold_q;
        last_byte  = cnt_q[CNT_W-1:3];
        done       = done_q;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (is_buf) begin
            reg_rdata = buf_rdata;
        end else begin
            case (reg_addr)
                A_CMD:   reg_rdata[BUSY_BIT]  = busy;
                A_CTRL:  reg_rdata[BUSEN_BIT] = busen_q;
                A_USER:  reg_rdata[CAPEN_BIT] = cap_q;
                A_LEN:   reg_rdata            = 32'(cnt_q);
                A_CSCTL: reg_rdata[HOLD_BIT]  = hold_q;
                A_SLV:   reg_rdata[DONE_BIT]  = done_q;
                default: reg_rdata = '0;
            endcase
        end
    end

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        fin && !soft_rst |=> done_q); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !wr_slv |=> done_q); // R6
endmodule

// File: rtl/sfc_xfer_engine.sv
// sfc_xfer_engine: top of the serial flash transfer engine.
// Connects the register file, the data window and the mode-0 sequencer to the pins.
// Assumes BUF_BYTES is a power of two of at least 64, so that the registers fit below the window.
module sfc_xfer_engine
    import sfc_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 64,
    parameter int unsigned HALF_DIV  = 2,
    parameter int unsigned ADDR_W    = $clog2(BUF_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int unsigned BYTE_IDX_W = $clog2(BUF_BYTES);
    localparam int unsigned CNT_W      = BYTE_IDX_W + 3;
    localparam int unsigned WORD_W     = BYTE_IDX_W - 2;

    logic [31:0]           buf_rdata;
    logic                  buf_we, eng_we;
    logic [WORD_W-1:0]     buf_word;
    logic [BYTE_IDX_W-1:0] eng_ridx, eng_widx, last_byte;
    logic [7:0]            eng_rbyte, eng_wbyte;
    logic                  busy, fin, start_req, soft_rst, capture_en, cs_hold, done;
    logic                  cs_act;

    sfc_regs #(.BUF_BYTES(BUF_BYTES), .BYTE_IDX_W(BYTE_IDX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_word(buf_word),
        .busy(busy), .fin(fin), .start_req(start_req), .soft_rst(soft_rst),
        .capture_en(capture_en), .cs_hold(cs_hold), .last_byte(last_byte), .done(done)
    );

    sfc_buffer #(.BUF_BYTES(BUF_BYTES), .BYTE_IDX_W(BYTE_IDX_W), .WORD_W(WORD_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .bus_we(buf_we), .bus_word(buf_word), .bus_wdata(reg_wdata),
        .bus_rdata(buf_rdata), .eng_ridx(eng_ridx), .eng_rbyte(eng_rbyte),
        .eng_we(eng_we), .eng_widx(eng_widx), .eng_wbyte(eng_wbyte)
    );

    sfc_shifter #(.BUF_BYTES(BUF_BYTES), .HALF_DIV(HALF_DIV), .BYTE_IDX_W(BYTE_IDX_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .soft_rst(soft_rst),
        .capture_en(capture_en), .cs_hold(cs_hold), .last_byte(last_byte), .miso(spi_miso),
        .buf_rbyte(eng_rbyte), .buf_ridx(eng_ridx), .buf_we(eng_we), .buf_widx(eng_widx),
        .buf_wbyte(eng_wbyte), .sck(spi_sck), .cs_act(cs_act), .mosi(spi_mosi),
        .busy(busy), .fin(fin)
    );

    // Chip select pin is active low.
    always_comb spi_cs_n = !cs_act;

    AST_CS_RELEASE_ON_SRST: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> spi_cs_n && !done); // R9
endmodule

// File: tb/test_sfc_xfer_engine.sv
module test_sfc_xfer_engine;
    localparam int H  = 2;
    localparam int NB = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sck, cs_n, mosi;
    logic        miso = 1'b0;

    always #2.5 clk = ~clk;

    sfc_xfer_engine #(.BUF_BYTES(NB), .HALF_DIV(H)) i_sfc_xfer_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0, rises = 0;
    logic [7:0] exp_buf [NB];
    logic [7:0] tx_snap [NB];
    logic [7:0] pat     [NB];
    bit m_busy, m_cs, m_done, m_hold, m_cap, m_was, sh_cap, sh_hold, live;
    int m_t, m_nbits;
    logic [8:0] sh_len;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int w);
        return {exp_buf[4*w+3], exp_buf[4*w+2], exp_buf[4*w+1], exp_buf[4*w]};
    endfunction

    // Behavioural reference: tracks time since start and the expected buffer.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cs = 0; m_done = 0; m_t = 0; sh_cap = 0; sh_hold = 0; sh_len = '0;
            for (int b = 0; b < NB; b++) exp_buf[b] = '0;
        end else begin
            m_was = m_busy;
            if (m_busy) begin
                m_t++;
                if (m_t == 2 * H * m_nbits) begin
                    m_busy = 0; m_done = 1; m_cs = m_hold;
                    if (m_cap) for (int b = 0; b < m_nbits / 8; b++) exp_buf[b] = pat[b];
                end
            end
            if (reg_wr) begin
                if (reg_addr[6]) begin
                    for (int k = 0; k < 4; k++) exp_buf[int'(reg_addr[5:2]) * 4 + k] = reg_wdata[8*k +: 8];
                end else begin
                    case (reg_addr)
                        7'h00: if (reg_wdata[18] && !m_was) begin
                            m_busy = 1; m_t = 0; m_cs = 1; m_hold = sh_hold; m_cap = sh_cap;
                            m_nbits = (int'(sh_len >> 3) + 1) * 8;
                            for (int b = 0; b < NB; b++) tx_snap[b] = exp_buf[b];
                        end
                        7'h1C: sh_cap = reg_wdata[0];
                        7'h20: sh_len = reg_wdata[8:0];
                        7'h2C: sh_hold = reg_wdata[30];
                        7'h30: if (reg_wdata[31]) begin m_busy = 0; m_cs = 0; m_done = 0; end
                               else m_done = reg_wdata[4];
                        default: ;
                    endcase
                end
            end
        end
    end

    // Flash model drives MISO; pins compared against the reference every clock.
    always @(negedge clk) begin : pin_cmp
        int bi;
        if (live) begin
            if (m_busy) begin
                bi = m_t / (2 * H);
                miso = pat[bi / 8][7 - bi % 8];
                check("R3", "sck", sck, ((m_t / H) % 2 == 1));
                check("R4", "mosi", mosi, tx_snap[bi / 8][7 - bi % 8]);
            end else begin
                miso = 1'b0;
                check("R3", "sck idle", sck, 0);
                check("R4", "mosi idle", mosi, 0);
            end
            check("R7", "cs_n", cs_n, !m_cs);
        end
    end

    always @(posedge sck) rises++;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, $sformatf("read 0x%h", a), reg_rdata, exp);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy);
        repeat (2) @(negedge clk);
    endtask

    localparam logic [31:0] START = 32'h1 << 18;

    initial begin
        for (int b = 0; b < NB; b++) pat[b] = 8'(b * 37 + 11) ^ 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        // R1: reset state
        check("R1", "cs_n reset", cs_n, 1);
        check("R1", "sck reset", sck, 0);
        rd(7'h00, 0, "R1");
        rd(7'h30, 0, "R1");
        rd(7'h40, 0, "R1");
        rd(7'h04, 0, "R1");
        rd(7'h08, 32'h1 << 17, "R10");
        // load window; R4 little-endian word mapping
        for (int w = 0; w < 16; w++) wr(7'(64 + 4 * w), 32'(w * 32'h0102_0304) ^ 32'h5A3C_0F96);
        rd(7'h4C, exp_word(3), "R4");
        // two bytes, no capture, no hold
        wr(7'h20, 15); wr(7'h1C, 0); wr(7'h2C, 0);
        rises = 0;
        wr(7'h00, START);
        rd(7'h00, START, "R2");
        wait_idle();
        check("R3", "rising edges 16 bits", rises, 16);
        rd(7'h30, 32'h10, "R6");
        rd(7'h00, 0, "R2");
        rd(7'h40, exp_word(0), "R5");
        check("R7", "cs released", cs_n, 1);
        // four bytes, capture, hold, second start ignored
        wr(7'h1C, 1); wr(7'h2C, 32'h1 << 30); wr(7'h20, 31); wr(7'h30, 0);
        rises = 0;
        wr(7'h00, START);
        repeat (10) @(negedge clk);
        wr(7'h00, START); // R8
        wait_idle();
        check("R8", "rising edges 32 bits", rises, 32);
        rd(7'h40, {pat[3], pat[2], pat[1], pat[0]}, "R5");
        rd(7'h44, exp_word(1), "R5");
        check("R7", "cs held", cs_n, 0);
        repeat (5) @(negedge clk);
        rd(7'h30, 32'h10, "R6");
        wr(7'h30, 0);
        rd(7'h30, 0, "R6");
        // count with nonzero low bits: 0x16 gives 24 bits
        wr(7'h1C, 0); wr(7'h2C, 0); wr(7'h20, 32'h16);
        rises = 0;
        wr(7'h00, START);
        wait_idle();
        check("R3", "rising edges 24 bits", rises, 24);
        check("R7", "cs released after held", cs_n, 1);
        // full window with capture
        wr(7'h1C, 1); wr(7'h20, 511);
        wr(7'h00, START);
        wait_idle();
        for (int w = 0; w < 16; w++) rd(7'(64 + 4 * w), exp_word(w), "R5");
        // soft reset with held chip select, then mid-burst
        wr(7'h1C, 0); wr(7'h2C, 32'h1 << 30); wr(7'h20, 7);
        wr(7'h00, START);
        wait_idle();
        check("R7", "cs held before srst", cs_n, 0);
        wr(7'h30, 32'h1 << 31);
        check("R9", "cs after srst idle", cs_n, 1);
        wr(7'h20, 63);
        wr(7'h00, START);
        repeat (30) @(negedge clk);
        wr(7'h30, 32'h1 << 31);
        rd(7'h00, 0, "R9");
        rd(7'h30, 0, "R9");
        check("R9", "cs after srst", cs_n, 1);
        check("R9", "sck after srst", sck, 0);
        rd(7'h48, exp_word(2), "R9");
        // R10 control bit storage
        wr(7'h08, 0);
        rd(7'h08, 0, "R10");
        wr(7'h08, 32'h1 << 17);
        rd(7'h08, 32'h1 << 17, "R10");
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule